// File: doc/BRIEF.md
# Delay-Line Time Stamp Encoder

This block turns one captured snapshot of a tapped delay line into a time stamp. Each tap holds a single comparison bit, and tap 0 is the stage nearest the line's input. The time since the last reference edge is the tap position where the stored word falls from high to low. This falling position is the fine code. A free-running period counter in the reference clock domain supplies the coarse part. Because the fine range of the line spans exactly one reference period, the counter value sits directly above the fine code in the stamp.

A constant calibration offset is subtracted from the joined value. When the fine code is smaller than the offset, the borrow is taken from the coarse field. A word with several falling positions means the line has gone non-monotonic. Such a word is still encoded from its lowest falling position and is marked with a bubble flag. A word with no falling position at all gets a separate no-edge flag instead of a code. Results are registered and carry a one-cycle valid pulse.

Top module: `tdc_stamp_encoder`

## Requirements
- R1: While reset is asserted, `stamp_valid_o`, `stamp_o`, `bubble_o` and `no_edge_o` are all zero.
- R2: `stamp_valid_o` is high for exactly the one cycle that follows each clock edge at which `capture_i` is sampled high, and it is low otherwise.
- R3: The fine code is the smallest index k in 1..STAGES-1 for which `taps_i[k-1]` is 1 and `taps_i[k]` is 0. Bit 0 of `taps_i` is stage 0.
- R4: The coarse value is the number of rising clock edges with reset released before the capturing edge, modulo 2^COARSE_W. With a zero offset, `stamp_o` is the coarse value in bits [TW-1:FINE_W] and the fine code in bits [FINE_W-1:0].
- R5: When a falling position exists, `stamp_o` equals (coarse·2^FINE_W + fine − `trim_i`) modulo 2^TW, so a negative fine result borrows one from the coarse field.
- R6: When the captured word has more than one falling position, `bubble_o` is 1 and the stamp is still built from the lowest falling position. Otherwise `bubble_o` is 0.
- R7: When the captured word has no falling position (all ones, all zeros, or only low-to-high steps), `no_edge_o` is 1, `bubble_o` is 0, and `stamp_o` holds the coarse value with a zero fine field and no offset applied.
- R8: In cycles without a capture, `stamp_o`, `bubble_o` and `no_edge_o` keep the values of the last result.
- R9: The coarse value advances by one every reference clock cycle and wraps from 2^COARSE_W−1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one period equals the full fine range |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_i | input | 1 | Strobe marking a valid tap snapshot |
| taps_i | input | STAGES | Latched comparison bits, bit 0 = stage 0 |
| trim_i | input | FINE_W | Calibration offset subtracted from the joined value |
| stamp_valid_o | output | 1 | One-cycle pulse qualifying the result |
| stamp_o | output | COARSE_W+FINE_W | Coarse count above the fine code, offset removed |
| bubble_o | output | 1 | More than one falling position was seen |
| no_edge_o | output | 1 | No falling position was seen |

## Verification
The bench builds the encoder with STAGES=16 and COARSE_W=6. This keeps the fine field at four bits and makes the coarse counter wrap after 64 cycles, so the wrap from 63 to 0 is reached within a short run. It is also reached by a borrow taken from a coarse value of zero on the very first capture. With only sixteen taps, every falling position from 1 to 15 and bubble patterns touching both ends of the line are cheap to drive. They are compared cycle by cycle against a behavioural model that scans the word with integers.

// File: rtl/tdc_stamp_pkg.sv
package tdc_stamp_pkg;

  // Classification of one captured tap word.
  typedef struct packed {
    logic found;   // at least one falling position exists
    logic multi;   // more than one falling position exists
  } fall_class_t;

  // Result flags as presented at the outputs.
  typedef struct packed {
    logic bubble;
    logic no_edge;
  } stamp_flags_t;

  function automatic stamp_flags_t flags_from_class(fall_class_t c);
    stamp_flags_t f;
    f.bubble  = c.found & c.multi;
    f.no_edge = ~c.found;
    return f;
  endfunction

endpackage

// File: rtl/tdc_fall_map.sv
module tdc_fall_map #(
  parameter int STAGES = 128
) (
  input  logic [STAGES-1:0] taps,
  output logic [STAGES-1:0] falls
);

  // Position 0 can never be a fall: there is no stage before it.
  assign falls[0] = 1'b0;

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_pair
      assign falls[k] = taps[k-1] & ~taps[k];
    end
  endgenerate

endmodule

// File: rtl/tdc_fall_encoder.sv
module tdc_fall_encoder
  import tdc_stamp_pkg::*;
#(
  parameter int STAGES = 128,
  parameter int FINE_W = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] falls,
  output logic [FINE_W-1:0] first_idx,
  output fall_class_t       cls
);

  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  logic [STAGES-1:0] low_mask;

  // Scan from the top so that the lowest fall is written last.
  always_comb begin
    first_idx = '0;
    cls.found = 1'b0;
    for (int k = STAGES - 1; k >= 1; k--) begin
      if (falls[k]) begin
        first_idx = FINE_W'(k);
        cls.found = 1'b1;
      end
    end
  end

  // More than one set bit: clearing the lowest set bit leaves something.
  assign cls.multi = (falls & (falls - ONE)) != '0;

  // Mask of positions strictly below the reported one.
  assign low_mask = (ONE << first_idx) - ONE;

  always_comb begin
    if (cls.found) begin
      // R3
      first_is_fall_chk: assert (falls[first_idx]);
      // R3
      none_below_chk: assert ((falls & low_mask) == '0);
    end
    if (cls.multi) begin
      // R6
      multi_has_first_chk: assert (cls.found);
    end
  end

endmodule

// File: rtl/tdc_coarse_count.sv
module tdc_coarse_count #(
  parameter int COARSE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [COARSE_W-1:0] count
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else begin
      count <= count + COARSE_W'(1);
      armed <= 1'b1;
    end
  end

  // R9
  period_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    count == $past(count) + COARSE_W'(1));

endmodule

// File: rtl/tdc_stamp_encoder.sv
module tdc_stamp_encoder
  import tdc_stamp_pkg::*;
#(
  parameter int STAGES   = 128,
  parameter int COARSE_W = 16,
  parameter int FINE_W   = $clog2(STAGES),
  parameter int TW       = COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture_i,
  input  logic [STAGES-1:0]   taps_i,
  input  logic [FINE_W-1:0]   trim_i,
  output logic                stamp_valid_o,
  output logic [TW-1:0]       stamp_o,
  output logic                bubble_o,
  output logic                no_edge_o
);

  // Join coarse and fine, then remove the offset; the borrow runs into
  // the coarse field through the full-width subtraction.
  function automatic logic [TW-1:0] trimmed_stamp(
    logic [COARSE_W-1:0] coarse,
    logic [FINE_W-1:0]   fine,
    logic [FINE_W-1:0]   trim
  );
    return {coarse, fine} - TW'(trim);
  endfunction

  function automatic logic [TW-1:0] bare_stamp(logic [COARSE_W-1:0] coarse);
    return {coarse, {FINE_W{1'b0}}};
  endfunction

  logic [STAGES-1:0]   falls;
  logic [FINE_W-1:0]   first_idx;
  fall_class_t         cls;
  logic [COARSE_W-1:0] coarse;
  stamp_flags_t        nxt_flags;
  logic [TW-1:0]       nxt_stamp;
  logic                armed;

  tdc_fall_map #(.STAGES(STAGES)) u_map (
    .taps  (taps_i),
    .falls (falls)
  );

  tdc_fall_encoder #(.STAGES(STAGES), .FINE_W(FINE_W)) u_enc (
    .falls     (falls),
    .first_idx (first_idx),
    .cls       (cls)
  );

  tdc_coarse_count #(.COARSE_W(COARSE_W)) u_coarse (
    .clk   (clk),
    .rst_n (rst_n),
    .count (coarse)
  );

  assign nxt_flags = flags_from_class(cls);
  assign nxt_stamp = cls.found ? trimmed_stamp(coarse, first_idx, trim_i)
                               : bare_stamp(coarse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_valid_o <= 1'b0;
      stamp_o       <= '0;
      bubble_o      <= 1'b0;
      no_edge_o     <= 1'b0;
      armed         <= 1'b0;
    end else begin
      armed         <= 1'b1;
      stamp_valid_o <= capture_i;
      if (capture_i) begin
        stamp_o   <= nxt_stamp;
        bubble_o  <= nxt_flags.bubble;
        no_edge_o <= nxt_flags.no_edge;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    capture_i |=> stamp_valid_o);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !capture_i |=> !stamp_valid_o);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !capture_i |=> ($stable(stamp_o) && $stable(bubble_o) && $stable(no_edge_o)));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(bubble_o && no_edge_o));
  // R7
  no_edge_bare_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (stamp_valid_o && no_edge_o) |-> (stamp_o[FINE_W-1:0] == '0));

endmodule

// File: tb/test_tdc_stamp_encoder.sv
module test_tdc_stamp_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int STAGES   = 16;
  localparam int COARSE_W = 6;
  localparam int FINE_W   = $clog2(STAGES);
  localparam int TW       = COARSE_W + FINE_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              capture;
  logic [STAGES-1:0] taps;
  logic [FINE_W-1:0] trim;
  logic              v_o;
  logic [TW-1:0]     s_o;
  logic              b_o;
  logic              n_o;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  string cur_tag = "R4";

  // behavioural model state
  logic          m_valid;
  logic [TW-1:0] m_ts;
  logic          m_bub;
  logic          m_ne;
  string         m_tag = "R1";

  tdc_stamp_encoder #(.STAGES(STAGES), .COARSE_W(COARSE_W)) i_tdc_stamp_encoder (
    .clk           (clk),
    .rst_n         (rst_n),
    .capture_i     (capture),
    .taps_i        (taps),
    .trim_i        (trim),
    .stamp_valid_o (v_o),
    .stamp_o       (s_o),
    .bubble_o      (b_o),
    .no_edge_o     (n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_first(logic [STAGES-1:0] w);
    for (int k = 1; k < STAGES; k++)
      if (w[k-1] == 1'b1 && w[k] == 1'b0) return k;
    return -1;
  endfunction

  function automatic int ref_count(logic [STAGES-1:0] w);
    int n = 0;
    for (int k = 1; k < STAGES; k++)
      if (w[k-1] == 1'b1 && w[k] == 1'b0) n++;
    return n;
  endfunction

  function automatic logic [STAGES-1:0] thermo(int k);
    logic [STAGES-1:0] w = '0;
    for (int i = 0; i < k; i++) w[i] = 1'b1;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference model, advanced on every edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_ts <= '0; m_bub <= 1'b0; m_ne <= 1'b0; cyc <= 0;
    end else begin
      int f, n, coarse, tot;
      cyc     <= cyc + 1;
      m_valid <= capture;
      if (capture) begin
        f      = ref_first(taps);
        n      = ref_count(taps);
        coarse = cyc % (1 << COARSE_W);
        if (f < 0) tot = coarse * (1 << FINE_W);
        else begin
          tot = coarse * (1 << FINE_W) + f - int'(trim);
          if (tot < 0) tot += (1 << TW);
        end
        m_ts  <= TW'(tot);
        m_bub <= (n > 1);
        m_ne  <= (f < 0);
        m_tag <= cur_tag;
      end else begin
        m_tag <= "R8";
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check("R2", 32'(v_o), 32'(m_valid));
      check(m_tag, 32'(s_o), 32'(m_ts));
      check("R6", 32'(b_o), 32'(m_bub));
      check("R7", 32'(n_o), 32'(m_ne));
    end
  end

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic shot(logic [STAGES-1:0] w, logic [FINE_W-1:0] t, string tag);
    capture = 1'b1; taps = w; trim = t; cur_tag = tag;
    @(negedge clk);
    capture = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; capture = 1'b0; taps = '0; trim = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", 32'(v_o), 0);
    check("R1", 32'(s_o), 0);
    check("R1", 32'(b_o), 0);
    check("R1", 32'(n_o), 0);
    rst_n = 1'b1;
    // R5 borrow from a zero coarse value on the first capture
    shot(thermo(1), 4'd2, "R5");
    // R3 clean thermometer words, back to back
    shot(thermo(5), 4'd0, "R3");
    shot(thermo(15), 4'd0, "R3");
    shot(thermo(1), 4'd0, "R3");
    shot(16'h8001, 4'd0, "R3");
    repeat (3) @(negedge clk);
    // R5 offset, with and without borrow
    shot(thermo(7), 4'd3, "R5");
    shot(thermo(4), 4'd9, "R5");
    @(negedge clk);
    // R6 bubbles: falls at 3,6,8 and at 1,15
    shot(16'h00B7, 4'd0, "R6");
    shot(16'h7FF9, 4'd1, "R6");
    // R7 no falling position
    shot(16'hFFFF, 4'd5, "R7");
    shot(16'h0000, 4'd0, "R7");
    shot(16'hFFF0, 4'd3, "R7");
    @(negedge clk);
    // R4 mixed patterns with idle gaps
    for (int i = 0; i < 40; i++) begin
      shot(STAGES'($urandom), FINE_W'($urandom), "R4");
      repeat ($urandom % 3) @(negedge clk);
    end
    for (int i = 1; i < STAGES; i++) shot(thermo(i), FINE_W'(i % 3), "R4");
    // R9 wrap of the coarse field
    while ((cyc % (1 << COARSE_W)) != (1 << COARSE_W) - 1) @(negedge clk);
    shot(thermo(3), 4'd0, "R9");
    check("R9", 32'(s_o[TW-1:FINE_W]), (1 << COARSE_W) - 1);
    shot(thermo(3), 4'd0, "R9");
    check("R9", 32'(s_o[TW-1:FINE_W]), 0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule